// File: doc/BRIEF.md
# Dual Down-Counter Timer Shell

This block places two independent prescaled down-counting timers behind one 4 KB register window. A bus master writes and reads 32-bit words; the shell decodes the low twelve address bits and steers each access to the first timer bank, the second timer bank, or a read-only block of eight identification bytes at the top of the window. Every other location reads as zero, and writes that reach no timer bank are dropped.

Each timer takes its own tick-enable input, so the two can count at different reference rates (nominally 1 MHz each, produced by the surrounding chip). Each timer has a load value, a current count, a control byte with a prescaler, an interrupt enable and three counting modes (free-running, periodic, one-shot), plus raw and masked interrupt status. The masked interrupts of the two timers are merged by logical OR into a single interrupt output.

Top module: `dual_timer_shell`

## Requirements
- R1: Byte offsets 0x00-0x1F address the first timer. Word 0 (0x00) writes the load value and the current count, word 6 (0x18) writes the load value only, and both read back the load value. Word 1 (0x04) reads the current count and ignores writes. Word 2 (0x08) is the control byte: bit 0 one-shot, bit 1 32-bit free-run width, bits 3:2 prescale (1 selects divide by 16, 2 selects divide by 256, others divide by 1), bit 5 interrupt enable, bit 6 periodic, bit 7 enable. A write to word 3 (0x0C) clears the raw interrupt. Word 4 (0x10) reads the raw interrupt and word 5 (0x14) the raw interrupt gated by the enable.
- R2: Offsets 0x20-0x3F address the second timer with the same word layout, 0x20 removed. An access to one timer changes nothing in the other.
- R3: Offsets 0xFE0-0xFFC read the bytes 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, one per word in that order, zero-extended to 32 bits. Writes there have no effect.
- R4: The test offsets 0xF00 and 0xF04 read zero, like every other offset outside the timer banks and the identification block. Writes outside the two timer banks change no register.
- R5: Only address bits 11:0 are decoded, so an address with any higher bits set reaches the same register as its low twelve bits.
- R6: The interrupt output is high whenever either timer's masked interrupt is high.
- R7: After reset each timer reads control 0x20, load value 0, count 0 and raw interrupt 0, and the interrupt output is low.
- R8: An enabled timer steps once for every prescaled tick. A step from a nonzero count decrements it. A step at count zero sets the raw interrupt and reloads the load value in periodic mode. In free-running mode it reloads all ones (0xFFFF when control bit 1 is clear).
- R9: The clear write drops the raw interrupt. Clearing the interrupt enable drops the masked status and the timer's share of the output, but keeps the raw interrupt.
- R10: With divide by 16 the timer steps on every sixteenth tick, counted from the last control write.
- R11: Each timer counts only on the cycles where its own tick-enable input is high.
- R12: In one-shot mode a step at count zero sets the raw interrupt, leaves the count at zero and clears the enable bit, so further ticks are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick0_en | input | 1 | Reference tick enable for the first timer |
| tick1_en | input | 1 | Reference tick enable for the second timer |
| wr_en | input | 1 | Write strobe for the word at addr |
| addr | input | 32 | Byte address; bits 11:0 decoded |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| irq | output | 1 | OR of both timers' masked interrupts |

## Verification
The decode is tried with offsets in each timer bank, their aliases with high address bits set, the identification words, the test offsets and unmapped space. Reading the other bank after each write tells correct steering apart from a missing or wrong 0x20 offset. Counting is tried with ticks on one timer while the other's ticks stay low, and with divide by 1, divide by 16 and one-shot. Reading the count one tick before and at each expected step separates an off-by-one step or reload from a correct one. The interrupt is driven from each timer in turn, with the enable both set and cleared, which shows the merge is an OR of masked rather than raw levels.

// File: rtl/dtw_pkg.sv
package dtw_pkg;

  // control byte bit positions
  localparam int unsigned CB_ONESHOT = 0;
  localparam int unsigned CB_WIDE    = 1;
  localparam int unsigned CB_PRE_LO  = 2;
  localparam int unsigned CB_IE      = 5;
  localparam int unsigned CB_PERIOD  = 6;
  localparam int unsigned CB_EN      = 7;

  localparam logic [7:0] CTRL_RESET = 8'h20;

  // register word indices inside one timer bank
  typedef enum logic [2:0] {
    W_LOAD  = 3'd0,
    W_COUNT = 3'd1,
    W_CTRL  = 3'd2,
    W_CLR   = 3'd3,
    W_RAW   = 3'd4,
    W_MASK  = 3'd5,
    W_BGLD  = 3'd6,
    W_RSVD  = 3'd7
  } dtw_word_e;

  function automatic logic [7:0] dtw_id_byte(input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0:    b = 8'h04;
      3'd1:    b = 8'h18;
      3'd2:    b = 8'h14;
      3'd3:    b = 8'h00;
      3'd4:    b = 8'h0D;
      3'd5:    b = 8'hF0;
      3'd6:    b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/dtw_decode.sv
module dtw_decode #(
  parameter int unsigned WIN_W    = 12,
  parameter int unsigned BANK_AW  = 5,
  parameter int unsigned N_TIMERS = 2,
  parameter logic [WIN_W-1:0] ID_BASE = 12'hFE0
) (
  input  logic [WIN_W-1:0]    win_off,
  output logic [N_TIMERS-1:0] bank_hit,
  output logic                id_hit,
  output logic [2:0]          word
);
  localparam int unsigned HI_W = WIN_W - BANK_AW;

  logic [1:0] unused_lsb;
  assign unused_lsb = win_off[1:0];

  assign word   = win_off[BANK_AW-1:2];
  assign id_hit = (win_off[WIN_W-1:BANK_AW] == ID_BASE[WIN_W-1:BANK_AW]);

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_bank
    assign bank_hit[i] = (win_off[WIN_W-1:BANK_AW] == HI_W'(i));
  end

  always_comb begin
    assert ($onehot0({bank_hit, id_hit}))
      else $error("p_single_target_r4: decode hits more than one target");
  end
endmodule

// File: rtl/dtw_timer.sv
module dtw_timer
  import dtw_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [2:0]        word,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam logic [DATA_W-1:0] FREE_NARROW = DATA_W'(16'hFFFF);

  logic [7:0]        ctrl_q,  ctrl_d;
  logic [DATA_W-1:0] limit_q, limit_d;
  logic [DATA_W-1:0] count_q, count_d;
  logic [PRE_W-1:0]  pre_q,   pre_d;
  logic              raw_q,   raw_d;
  logic              pre_tick, fire, step;

  assign pre_tick = ctrl_q[CB_EN] & tick_en;

  always_comb begin
    case (ctrl_q[CB_PRE_LO +: 2])
      2'd1:    fire = (pre_q[3:0] == 4'hF);
      2'd2:    fire = (pre_q == '1);
      default: fire = 1'b1;
    endcase
  end

  assign step = pre_tick & fire;

  always_comb begin
    ctrl_d  = ctrl_q;
    limit_d = limit_q;
    count_d = count_q;
    pre_d   = pre_tick ? pre_q + 1'b1 : pre_q;
    raw_d   = raw_q;

    if (wr_en && word == W_CLR) raw_d = 1'b0;

    if (step) begin
      if (count_q == '0) begin
        raw_d = 1'b1;
        if (ctrl_q[CB_ONESHOT])     ctrl_d[CB_EN] = 1'b0;
        else if (ctrl_q[CB_PERIOD]) count_d = limit_q;
        else if (ctrl_q[CB_WIDE])   count_d = '1;
        else                        count_d = FREE_NARROW;
      end else begin
        count_d = count_q - 1'b1;
      end
    end

    if (wr_en) begin
      case (word)
        W_LOAD: begin
          limit_d = wdata;
          count_d = wdata;
        end
        W_CTRL: begin
          ctrl_d = wdata[7:0];
          pre_d  = '0;
        end
        W_BGLD:  limit_d = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RESET;
      limit_q <= '0;
      count_q <= '0;
      pre_q   <= '0;
      raw_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      limit_q <= limit_d;
      count_q <= count_d;
      pre_q   <= pre_d;
      raw_q   <= raw_d;
    end
  end

  assign irq = raw_q & ctrl_q[CB_IE];

  always_comb begin
    case (word)
      W_LOAD, W_BGLD: rdata = limit_q;
      W_COUNT:        rdata = count_q;
      W_CTRL:         rdata = {{(DATA_W-8){1'b0}}, ctrl_q};
      W_RAW:          rdata = {{(DATA_W-1){1'b0}}, raw_q};
      W_MASK:         rdata = {{(DATA_W-1){1'b0}}, irq};
      default:        rdata = '0;
    endcase
  end

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr_en) |=> $stable(count_q));

  p_zero_raises_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count_q == '0) |=> raw_q);

  p_oneshot_stop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count_q == '0 && ctrl_q[CB_ONESHOT] && !wr_en) |=> !ctrl_q[CB_EN]);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == W_CLR && !step) |=> !raw_q);
endmodule

// File: rtl/dual_timer_shell.sv
module dual_timer_shell
  import dtw_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned WIN_W    = 12,
  parameter int unsigned BANK_AW  = 5,
  parameter int unsigned PRE_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick0_en,
  input  logic              tick1_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int unsigned N_TIMERS = 2;

  logic [ADDR_W-WIN_W-1:0] unused_hi;
  assign unused_hi = addr[ADDR_W-1:WIN_W];

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [N_TIMERS-1:0] bank_hit;
  logic                id_hit;
  logic [2:0]          word;
  logic [N_TIMERS-1:0] tick_vec;
  logic [N_TIMERS-1:0] t_irq;
  logic [DATA_W-1:0]   t_rdata [N_TIMERS];

  assign tick_vec = {tick1_en, tick0_en};

  dtw_decode #(
    .WIN_W   (WIN_W),
    .BANK_AW (BANK_AW),
    .N_TIMERS(N_TIMERS)
  ) u_decode (
    .win_off (addr[WIN_W-1:0]),
    .bank_hit(bank_hit),
    .id_hit  (id_hit),
    .word    (word)
  );

  for (genvar i = 0; i < N_TIMERS; i++) begin : g_tmr
    dtw_timer #(
      .DATA_W(DATA_W),
      .PRE_W (PRE_W)
    ) u_timer (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .tick_en(tick_vec[i]),
      .wr_en  (wr_en & bank_hit[i]),
      .word   (word),
      .wdata  (wdata),
      .rdata  (t_rdata[i]),
      .irq    (t_irq[i])
    );
  end

  always_comb begin
    rdata = '0;
    if (id_hit) rdata = {{(DATA_W-8){1'b0}}, dtw_id_byte(word)};
    for (int i = 0; i < N_TIMERS; i++) begin
      if (bank_hit[i]) rdata = t_rdata[i];
    end
  end

  assign irq = |t_irq;

  p_id_zero_ext_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    id_hit |-> (rdata[DATA_W-1:8] == '0));

  p_unmapped_zero_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!id_hit && bank_hit == '0) |-> (rdata == '0));

  p_irq_follows_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (t_irq != '0) |-> irq);
endmodule

// File: tb/dual_timer_shell_tb.sv
`timescale 1ns/1ps
module dual_timer_shell_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick0_en, tick1_en, wr_en;
  logic [31:0] addr, wdata, rdata;
  logic        irq;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  dual_timer_shell u_dut (
    .clk(clk), .rst_n(rst_n), .tick0_en(tick0_en), .tick1_en(tick1_en),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    #1 d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [31:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic irq_chk(input string req, input logic exp);
    @(negedge clk);
    #1 chk(req, {31'b0, irq}, {31'b0, exp});
  endtask

  task automatic tick(input int which, input int n);
    @(negedge clk);
    if (which == 0) tick0_en = 1'b1; else tick1_en = 1'b1;
    repeat (n) @(posedge clk);
    #1 begin tick0_en = 1'b0; tick1_en = 1'b0; end
  endtask

  task automatic t_reset_r7;
    rd_chk("R7 ctrl0", 32'h08, 32'h20);
    rd_chk("R7 ctrl1", 32'h28, 32'h20);
    rd_chk("R7 load0", 32'h00, 32'h0);
    rd_chk("R7 count1", 32'h24, 32'h0);
    rd_chk("R7 raw0", 32'h10, 32'h0);
    irq_chk("R7 irq", 1'b0);
  endtask

  task automatic t_bank0_r1;
    wr(32'h00, 32'h1234_5678);
    rd_chk("R1 load", 32'h00, 32'h1234_5678);
    rd_chk("R1 bgload read", 32'h18, 32'h1234_5678);
    rd_chk("R1 count", 32'h04, 32'h1234_5678);
    wr(32'h04, 32'h0);
    rd_chk("R1 count write ignored", 32'h04, 32'h1234_5678);
  endtask

  task automatic t_bank1_r2;
    rd_chk("R2 timer1 untouched", 32'h20, 32'h0);
    wr(32'h38, 32'h0000_ABCD);
    rd_chk("R2 timer1 load", 32'h20, 32'h0000_ABCD);
    rd_chk("R2 timer1 count kept", 32'h24, 32'h0);
    rd_chk("R2 timer0 untouched", 32'h00, 32'h1234_5678);
  endtask

  task automatic t_alias_r5;
    wr(32'h7000_1000, 32'h55);
    rd_chk("R5 alias write", 32'h000, 32'h55);
    rd_chk("R5 alias read", 32'h3000_0018, 32'h55);
  endtask

  task automatic t_id_r3;
    logic [7:0] exp_id [8] = '{8'h04, 8'h18, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 8; i++)
      rd_chk("R3 id byte", 32'hFE0 + 32'(i * 4), {24'b0, exp_id[i]});
    wr(32'hFE0, 32'hFFFF_FFFF);
    rd_chk("R3 id write ignored", 32'hFE0, 32'h04);
  endtask

  task automatic t_unmapped_r4;
    wr(32'h040, 32'hFFFF_FFFF);
    wr(32'hF00, 32'hFFFF_FFFF);
    rd_chk("R4 test ctrl", 32'hF00, 32'h0);
    rd_chk("R4 test out", 32'hF04, 32'h0);
    rd_chk("R4 unmapped", 32'h040, 32'h0);
    rd_chk("R4 unmapped mid", 32'h800, 32'h0);
    rd_chk("R4 ctrl0 kept", 32'h08, 32'h20);
    rd_chk("R4 ctrl1 kept", 32'h28, 32'h20);
  endtask

  task automatic t_periodic_r8_r9;
    wr(32'h00, 32'd3);
    wr(32'h08, 32'hE0);
    tick(0, 3);
    rd_chk("R8 count after 3 steps", 32'h04, 32'd0);
    irq_chk("R8 no irq before wrap", 1'b0);
    tick(0, 1);
    rd_chk("R8 periodic reload", 32'h04, 32'd3);
    irq_chk("R8 irq at wrap", 1'b1);
    rd_chk("R9 masked set", 32'h14, 32'h1);
    wr(32'h08, 32'hC0);
    irq_chk("R9 irq masked off", 1'b0);
    rd_chk("R9 raw kept", 32'h10, 32'h1);
    rd_chk("R9 masked clear", 32'h14, 32'h0);
    wr(32'h0C, 32'h0);
    rd_chk("R9 raw cleared", 32'h10, 32'h0);
  endtask

  task automatic t_prescale_r10_r6;
    wr(32'h20, 32'd2);
    wr(32'h28, 32'hE4);
    tick(1, 15);
    rd_chk("R10 no step before 16", 32'h24, 32'd2);
    tick(1, 1);
    rd_chk("R10 step at 16", 32'h24, 32'd1);
    rd_chk("R11 timer0 held", 32'h04, 32'd3);
    tick(1, 32);
    rd_chk("R6 timer1 raw", 32'h30, 32'h1);
    irq_chk("R6 irq from timer1", 1'b1);
    wr(32'h2C, 32'h0);
    irq_chk("R6 irq dropped", 1'b0);
  endtask

  task automatic t_oneshot_r12;
    wr(32'h00, 32'd1);
    wr(32'h08, 32'hA1);
    tick(0, 2);
    rd_chk("R12 enable cleared", 32'h08, 32'h21);
    rd_chk("R12 count at zero", 32'h04, 32'd0);
    irq_chk("R12 irq", 1'b1);
    tick(0, 3);
    rd_chk("R12 stays stopped", 32'h04, 32'd0);
    rd_chk("R11 timer1 held", 32'h24, 32'd2);
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; tick0_en = 1'b0; tick1_en = 1'b0; wr_en = 1'b0;
    addr = '0; wdata = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset_r7();
    t_bank0_r1();
    t_bank1_r2();
    t_alias_r5();
    t_id_r3();
    t_unmapped_r4();
    t_periodic_r8_r9();
    t_prescale_r10_r6();
    t_oneshot_r12();
    done = 1;
    finish_run();
  end
endmodule